// File: doc/BRIEF.md
# Double-Buffered PWM Compare Register Bank

This block holds the four 12-bit compare thresholds of one PWM channel, here called RA, RB, SA and SB. An 8-bit processor bus writes them one byte at a time. A shared holding byte collects the upper half, and the lower-half write then lands both halves in a 16-bit shadow word in the same clock edge. The PWM timebase sees only the active copies. They are refreshed from the shadows under one of three policies: immediate transfer, a lock that holds updates until it is released, or an auto-lock that commits the whole bank at the cycle boundary once RB has been the most recent register written.

The active values are compared against the timebase count, which comes from outside the block, and give one match flag per register. RB also carries a 4-bit flank-width field in its top nibble, and the block passes that field on to the waveform logic. In half-duty mode software programs only RB and SB. Each RB update copies RB's threshold into RA and SB's threshold into SA.

Top module: `pwm_cmp_bank`

## Requirements
- R1: After reset, every shadow word, every active threshold, the holding byte and the flank-width output are zero.
- R2: A write with `wr_addr[0]`=1 (upper half) loads only the shared holding byte. No shadow word or active threshold changes.
- R3: A write with `wr_addr[0]`=0 (lower half) stores {holding byte, write data} into the shadow word selected by `wr_addr[2:1]` (0=RA, 1=RB, 2=SA, 3=SB) in one edge. The holding byte is shared, so the most recent upper-half write to any register supplies the upper half.
- R4: The shadow words of RA, SA and SB keep only 12 bits, so their bits 15:12 always read back as zero. RB keeps all 16 bits. `rd_data` returns the upper or lower byte of the shadow word chosen by `rd_addr` with the same encoding as writes.
- R5: With lock and auto-lock both clear, the whole active bank equals the shadow bank one edge after a lower-half write.
- R6: With lock set and auto-lock clear, the active bank does not change. Writes made while not in immediate mode are transferred at the first `cycle_end` pulse seen with both lock and auto-lock clear.
- R7: With auto-lock set, the active bank changes only at a `cycle_end` pulse, and only if the last lower-half write was to RB. A lower-half write to RA, SA or SB cancels the pending commit, and each commit consumes the RB flag.
- R8: When auto-lock is set, lock has no effect.
- R9: With half-duty mode set, a lower-half write to RB also sets shadow RA to RB's 12-bit threshold and shadow SA to shadow SB.
- R10: `match[i]` is high exactly when active threshold i (bit 0=RA, 1=RB, 2=SA, 3=SB) equals `count` in that same cycle.
- R11: `flank_width` equals bits 15:12 of the active RB word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | [2:1] register select, [0] 1=upper half |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 3 | Read byte select, same encoding |
| rd_data | output | 8 | Shadow byte read back |
| cfg_lock | input | 1 | Hold transfers until released |
| cfg_autolock | input | 1 | Commit at cycle end after an RB write |
| cfg_fifty | input | 1 | Half-duty mirroring mode |
| cycle_end | input | 1 | One-cycle pulse at the PWM period boundary |
| count | input | 12 | Timebase count |
| ra_act | output | 12 | Active RA threshold |
| rb_act | output | 12 | Active RB threshold |
| sa_act | output | 12 | Active SA threshold |
| sb_act | output | 12 | Active SB threshold |
| match | output | 4 | Per-register equality flags |
| flank_width | output | 4 | Active RB flank-width field |

## Verification
A shadow word and its read-back byte are due one edge after the lower-half write. An active threshold is due one edge after that write in immediate mode, or one edge after the qualifying `cycle_end` pulse. `match` and `flank_width` are combinational from the active words and `count`, so they are valid in the same cycle as the active value. The bench drives every input at the falling edge, advances the reference model at the rising edge, and compares at the next falling edge. Each expected value is therefore taken exactly one register stage after its cause.

// File: rtl/cmp_bank_pkg.sv
// Shared constants for the compare register bank.
// Assumes exactly four registers, selected by a 2-bit field.
package cmp_bank_pkg;
    localparam int NREG = 4;
    localparam logic [1:0] SEL_RA = 2'd0;
    localparam logic [1:0] SEL_RB = 2'd1;
    localparam logic [1:0] SEL_SA = 2'd2;
    localparam logic [1:0] SEL_SB = 2'd3;
endpackage

// File: rtl/cmp_wr_port.sv
// Byte write port. Upper-half writes fill a shared holding byte. Lower-half
// writes land a full word in the shadow bank, with masking and half-duty
// mirroring. Assumes at most one byte write per cycle.
module cmp_wr_port
    import cmp_bank_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CMP_W = 12,
    localparam int REG_W = 2 * DW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_addr,
    input  logic [DW-1:0]              wr_data,
    input  logic                       fifty,
    output logic [NREG-1:0][REG_W-1:0] shadow_q,
    output logic [NREG-1:0][REG_W-1:0] shadow_nx,
    output logic                       low_wr,
    output logic [1:0]                 low_sel
);
    logic [DW-1:0]    hold_q;
    logic [REG_W-1:0] word;

    assign low_wr  = wr_en && !wr_addr[0];
    assign low_sel = wr_addr[2:1];

    // Capture the upper byte into the shared holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)                    hold_q <= '0;
        else if (wr_en && wr_addr[0])  hold_q <= wr_data;
    end

    // Build the next shadow bank from a completed word write.
    always_comb begin
        shadow_nx = shadow_q;
        word      = {hold_q, wr_data};
        if (low_sel != SEL_RB) word[REG_W-1:CMP_W] = '0;
        if (low_wr) begin
            shadow_nx[low_sel] = word;
            if (fifty && low_sel == SEL_RB) begin
                shadow_nx[SEL_RA] = {{(REG_W-CMP_W){1'b0}}, word[CMP_W-1:0]};
                shadow_nx[SEL_SA] = shadow_q[SEL_SB];
            end
        end
    end

    // Register the shadow bank.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_nx;
    end
endmodule

// File: rtl/cmp_commit.sv
// Transfer policy from shadow to active bank: immediate, lock-held,
// or auto-lock at the cycle boundary gated by the RB-last flag.
// Assumes cycle_end is a one-cycle pulse from the timebase.
module cmp_commit
    import cmp_bank_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lock,
    input  logic                       autolock,
    input  logic                       cycle_end,
    input  logic                       low_wr,
    input  logic [1:0]                 low_sel,
    input  logic [NREG-1:0][REG_W-1:0] shadow_q,
    input  logic [NREG-1:0][REG_W-1:0] shadow_nx,
    output logic [NREG-1:0][REG_W-1:0] active_q
);
    logic rb_last_q, pending_q;
    logic free_mode, auto_fire, rel_fire, fire;

    assign free_mode = !lock && !autolock;
    assign auto_fire = autolock && cycle_end && rb_last_q;
    assign rel_fire  = free_mode && cycle_end && pending_q;
    assign fire      = auto_fire || rel_fire;

    // Load the active bank at once or at a qualifying boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                   active_q <= '0;
        else if (free_mode && low_wr) active_q <= shadow_nx;
        else if (fire)                active_q <= shadow_q;
    end

    // Track whether RB was the most recent completed write.
    always_ff @(posedge clk) begin
        if (!rst_n)      rb_last_q <= 1'b0;
        else if (low_wr) rb_last_q <= (low_sel == SEL_RB);
        else if (fire)   rb_last_q <= 1'b0;
    end

    // Remember writes that have not yet reached the active bank.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending_q <= 1'b0;
        else if (low_wr) pending_q <= !free_mode;
        else if (fire)   pending_q <= 1'b0;
    end
endmodule

// File: rtl/cmp_match.sv
// Equality comparators between each active threshold and the count.
// Assumes the threshold sits in the low CMP_W bits of each word.
module cmp_match
    import cmp_bank_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CMP_W = 12
) (
    input  logic [NREG-1:0][REG_W-1:0] active,
    input  logic [CMP_W-1:0]           count,
    output logic [NREG-1:0]            match
);
    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        // One comparator per register.
        assign match[i] = (active[i][CMP_W-1:0] == count);
    end
endmodule

// File: rtl/pwm_cmp_bank.sv
// Top of the compare register bank: byte write port, commit policy,
// comparators and shadow read-back. Assumes a single clock domain.
module pwm_cmp_bank
    import cmp_bank_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CMP_W = 12,
    localparam int REG_W = 2 * DW,
    localparam int FW_W  = REG_W - CMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [2:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             cfg_lock,
    input  logic             cfg_autolock,
    input  logic             cfg_fifty,
    input  logic             cycle_end,
    input  logic [CMP_W-1:0] count,
    output logic [CMP_W-1:0] ra_act,
    output logic [CMP_W-1:0] rb_act,
    output logic [CMP_W-1:0] sa_act,
    output logic [CMP_W-1:0] sb_act,
    output logic [NREG-1:0]  match,
    output logic [FW_W-1:0]  flank_width
);
    logic [NREG-1:0][REG_W-1:0] shadow_q, shadow_nx, active_q;
    logic                       low_wr;
    logic [1:0]                 low_sel;
    logic [REG_W-1:0]           rd_word;

    cmp_wr_port #(.DW(DW), .CMP_W(CMP_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fifty(cfg_fifty), .shadow_q(shadow_q),
        .shadow_nx(shadow_nx), .low_wr(low_wr), .low_sel(low_sel)
    );

    cmp_commit #(.REG_W(REG_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .lock(cfg_lock), .autolock(cfg_autolock),
        .cycle_end(cycle_end), .low_wr(low_wr), .low_sel(low_sel),
        .shadow_q(shadow_q), .shadow_nx(shadow_nx), .active_q(active_q)
    );

    cmp_match #(.REG_W(REG_W), .CMP_W(CMP_W)) u_match (
        .active(active_q), .count(count), .match(match)
    );

    // Select the addressed shadow byte for read-back.
    always_comb begin
        rd_word = shadow_q[rd_addr[2:1]];
        rd_data = rd_addr[0] ? rd_word[REG_W-1:DW] : rd_word[DW-1:0];
    end

    assign ra_act      = active_q[SEL_RA][CMP_W-1:0];
    assign rb_act      = active_q[SEL_RB][CMP_W-1:0];
    assign sa_act      = active_q[SEL_SA][CMP_W-1:0];
    assign sb_act      = active_q[SEL_SB][CMP_W-1:0];
    assign flank_width = active_q[SEL_RB][REG_W-1:CMP_W];
endmodule

// File: rtl/cmp_bank_chk.sv
// Protocol checker for the compare bank, bound to the top module.
module cmp_bank_chk
    import cmp_bank_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CMP_W = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [2:0]                 wr_addr,
    input logic                       cfg_lock,
    input logic                       cfg_autolock,
    input logic                       cycle_end,
    input logic [NREG-1:0][REG_W-1:0] shadow,
    input logic [NREG-1:0][REG_W-1:0] active
);
    // R2: an upper-half write leaves the shadow bank untouched
    a_r2_hi_keeps_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[0]) |=> $stable(shadow));

    // R4: the 12-bit registers never hold upper bits
    a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow[SEL_RA][REG_W-1:CMP_W] == '0) && (shadow[SEL_SA][REG_W-1:CMP_W] == '0)
        && (shadow[SEL_SB][REG_W-1:CMP_W] == '0));

    // R5: in immediate mode the active bank tracks a completed write
    a_r5_free_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_lock && !cfg_autolock && wr_en && !wr_addr[0]) |=> (active == shadow));

    // R6: lock without auto-lock freezes the active bank
    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock && !cfg_autolock) |=> $stable(active));

    // R7: with auto-lock, nothing changes away from the cycle boundary
    a_r7_auto_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_autolock && !cycle_end) |=> $stable(active));
endmodule

bind pwm_cmp_bank cmp_bank_chk #(.REG_W(REG_W), .CMP_W(CMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .cfg_lock(cfg_lock), .cfg_autolock(cfg_autolock), .cycle_end(cycle_end),
    .shadow(shadow_q), .active(active_q)
);

// File: tb/tb_pwm_cmp_bank.sv
`timescale 1ns/1ps
module tb_pwm_cmp_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [2:0]  rd_addr;
    logic [7:0]  rd_data;
    logic        cfg_lock, cfg_autolock, cfg_fifty, cycle_end;
    logic [11:0] count;
    logic [11:0] ra_act, rb_act, sa_act, sb_act;
    logic [3:0]  match;
    logic [3:0]  flank_width;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state
    logic [7:0]  m_hold;
    logic [15:0] m_sh [4];
    logic [15:0] m_act [4];
    logic        m_rbl, m_pend;

    always #2.5 clk = ~clk;

    pwm_cmp_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_lock(cfg_lock), .cfg_autolock(cfg_autolock), .cfg_fifty(cfg_fifty),
        .cycle_end(cycle_end), .count(count), .ra_act(ra_act), .rb_act(rb_act),
        .sa_act(sa_act), .sb_act(sb_act), .match(match), .flank_width(flank_width)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Advance the reference by one edge using the inputs now applied.
    task automatic model_step();
        logic [15:0] nx [4];
        logic [15:0] w;
        logic        lw, fr, fire;
        logic [1:0]  sel;
        nx  = m_sh;
        lw  = wr_en && !wr_addr[0];
        sel = wr_addr[2:1];
        fr  = !cfg_lock && !cfg_autolock;
        if (lw) begin
            w = {m_hold, wr_data};
            if (sel != 2'd1) w[15:12] = 4'h0;
            nx[sel] = w;
            if (cfg_fifty && sel == 2'd1) begin
                nx[0] = {4'h0, w[11:0]};
                nx[2] = m_sh[3];
            end
        end
        fire = (cfg_autolock && cycle_end && m_rbl) || (fr && cycle_end && m_pend);
        if (fr && lw) m_act = nx;
        else if (fire) m_act = m_sh;
        if (lw) begin m_rbl = (sel == 2'd1); m_pend = !fr; end
        else if (fire) begin m_rbl = 1'b0; m_pend = 1'b0; end
        if (!rst_n) begin
            m_hold = 8'h00; m_rbl = 1'b0; m_pend = 1'b0;
            for (int i = 0; i < 4; i++) begin nx[i] = '0; m_act[i] = '0; end
        end else if (wr_en && wr_addr[0]) m_hold = wr_data;
        m_sh = nx;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 1'b0; cycle_end = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic wr16(input logic [1:0] sel, input logic [15:0] v);
        wr({sel, 1'b1}, v[15:8]);
        wr({sel, 1'b0}, v[7:0]);
    endtask

    task automatic boundary();
        cycle_end = 1'b1;
        tick();
    endtask

    function automatic logic [3:0] exp_match();
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = (m_act[i][11:0] == count);
        return m;
    endfunction

    task automatic compare_all(input string req);
        chk({req, " ra"}, ra_act, m_act[0][11:0]);
        chk({req, " rb"}, rb_act, m_act[1][11:0]);
        chk({req, " sa"}, sa_act, m_act[2][11:0]);
        chk({req, " sb"}, sb_act, m_act[3][11:0]);
        chk({req, " R10 match"}, match, exp_match());
        chk({req, " R11 flank"}, flank_width, m_act[1][15:12]);
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #0.1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        cfg_lock = 1'b0; cfg_autolock = 1'b0; cfg_fifty = 1'b0;
        cycle_end = 1'b0; count = 12'h123;
        @(negedge clk);
        wr(3'd1, 8'h5A);          // write during reset must be discarded
        tick(); tick();
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) rd_chk("R1 shadow byte", a[2:0], 8'h00);
        chk("R1 ra", ra_act, 12'h000);
        chk("R1 flank", flank_width, 4'h0);
        wr(3'd0, 8'h00);
        rd_chk("R1 holding byte", 3'd1, 8'h00);

        // R2: upper half alone changes nothing visible
        wr(3'd1, 8'hAB);
        rd_chk("R2 RA high unchanged", 3'd1, 8'h00);
        chk("R2 ra active unchanged", ra_act, 12'h000);
        // R3/R4/R5: lower half completes the word, upper nibble dropped
        wr(3'd0, 8'hCD);
        chk("R5 ra immediate", ra_act, 12'hBCD);
        rd_chk("R4 RA high masked", 3'd1, 8'h0B);
        rd_chk("R3 RA low", 3'd0, 8'hCD);

        // R3: holding byte shared across registers
        wr(3'd3, 8'h9F);          // upper half via RB address
        wr(3'd6, 8'h12);          // lower half of SB
        chk("R3 shared holding sb", sb_act, 12'hF12);
        wr16(2'd1, 16'h9F34);
        chk("R5 rb immediate", rb_act, 12'hF34);
        chk("R11 flank from rb", flank_width, 4'h9);
        rd_chk("R4 RB keeps upper bits", 3'd3, 8'h9F);

        // R6: lock holds, release takes effect at next boundary
        cfg_lock = 1'b1;
        wr16(2'd2, 16'h0456);
        chk("R6 sa held", sa_act, 12'h000);
        boundary();
        chk("R6 sa held at boundary", sa_act, 12'h000);
        cfg_lock = 1'b0;
        tick();
        chk("R6 sa waits for boundary", sa_act, 12'h000);
        boundary();
        chk("R6 sa released", sa_act, 12'h456);

        // R7: auto-lock needs RB last
        cfg_autolock = 1'b1;
        wr16(2'd0, 16'h0111);
        boundary();
        chk("R7 no commit without RB", ra_act, 12'hBCD);
        wr16(2'd1, 16'h0222);
        tick();
        chk("R7 no commit before boundary", rb_act, 12'hF34);
        boundary();
        chk("R7 commit ra", ra_act, 12'h111);
        chk("R7 commit rb", rb_act, 12'h222);
        wr16(2'd1, 16'h0333);
        wr16(2'd3, 16'h0444);     // non-RB write cancels
        boundary();
        chk("R7 cancelled by SB write", rb_act, 12'h222);

        // R8: auto-lock prevails over lock
        cfg_lock = 1'b1;
        wr16(2'd1, 16'h0777);
        boundary();
        chk("R8 commit despite lock rb", rb_act, 12'h777);
        chk("R8 commit despite lock sb", sb_act, 12'h444);
        cfg_lock = 1'b0; cfg_autolock = 1'b0;

        // R9: half-duty mirroring
        cfg_fifty = 1'b1;
        wr16(2'd3, 16'h0AAA);
        wr16(2'd1, 16'h1BBB);
        chk("R9 ra mirrors rb", ra_act, 12'hBBB);
        chk("R9 sa mirrors sb", sa_act, 12'hAAA);
        chk("R11 flank 1", flank_width, 4'h1);
        rd_chk("R9 RA shadow high", 3'd1, 8'h0B);

        // R10: match flags
        count = 12'hBBB; #0.1;
        chk("R10 match ra rb", match, 4'b0011);
        count = 12'hAAA; #0.1;
        chk("R10 match sa sb", match, 4'b1100);
        count = 12'h123; #0.1;
        chk("R10 no match", match, 4'b0000);
        cfg_fifty = 1'b0;

        // Random phase against the reference
        for (int c = 0; c < 3000; c++) begin
            wr_en     = ($urandom_range(0, 1) == 1);
            wr_addr   = 3'($urandom_range(0, 7));
            wr_data   = 8'($urandom_range(0, 255));
            cycle_end = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 39) == 0) begin
                cfg_lock     = ($urandom_range(0, 1) == 1);
                cfg_autolock = ($urandom_range(0, 1) == 1);
                cfg_fifty    = ($urandom_range(0, 1) == 1);
            end
            if ($urandom_range(0, 1) == 1) count = m_act[$urandom_range(0, 3)][11:0];
            else                           count = 12'($urandom_range(0, 4095));
            @(posedge clk);
            model_step();
            @(negedge clk);
            wr_en = 1'b0; cycle_end = 1'b0;
            compare_all("R5 R6 R7 R8 R9 random");
            rd_addr = 3'($urandom_range(0, 7));
            #0.1;
            chk("R3 R4 random readback", rd_data,
                rd_addr[0] ? m_sh[rd_addr[2:1]][15:8] : m_sh[rd_addr[2:1]][7:0]);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule